// File: doc/BRIEF.md
# Serial Configuration Register Target

This block is a byte-oriented two-wire serial bus target that owns a small bank of byte-wide configuration registers. It oversamples the bus clock and data lines with the system clock, cleans them through a synchroniser and a glitch filter, and recognises start and stop conditions. It answers only to a seven-bit identity made of a fixed `0101` prefix and three strap inputs. After the identity it takes a register address, then either one data byte to write or a stream of read data.

A write is held pending and is applied to the register bank only when the stop condition arrives. At that point a one-cycle commit strobe reports the address and data. Reads come from an internal pointer. The address byte loads the pointer, each byte sent advances it, and it keeps its value between transactions. A current-address read therefore continues from where the last access ended, and a random read uses a dummy write followed by a repeated start. The block drives the data line only as an active-high pull-down enable.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset the pull-down output is low, all five registers read zero on `cfg_o`, and no commit strobe occurs.
- R2: The target acknowledges a byte after a start only if its upper seven bits are `0101` followed by `strap_i[2:0]`. Bit 0 of that byte selects the direction: 1 reads and 0 writes. On a mismatch it does not acknowledge, and it ignores the bus until the next start.
- R3: A write is start, identity byte with bit 0 = 0, address byte, data byte and stop, and each of the three bytes is acknowledged. The register keeps its old value until the stop. At the stop it takes the data, and `commit_valid_o` pulses for one cycle with that address and data.
- R4: A stop that arrives before a complete data byte and its acknowledge clock leaves every register unchanged and gives no commit strobe.
- R5: The register pointer keeps its value across transactions, so a read that begins with the identity byte alone returns data from the current pointer.
- R6: A random read is a dummy write of the address, then a repeated start and the identity byte with bit 0 = 1. It returns the addressed register, most significant bit first.
- R7: After each byte it sends, the target advances the pointer by one. It sends the next byte while the controller acknowledges. After a controller non-acknowledge it releases the data line.
- R8: A write to an address of 5 or above is acknowledged but changes no register and gives no commit strobe.
- R9: Within one write, any data byte after the first is not acknowledged, and only the first data byte is committed.
- R10: A clock pulse shorter than `FILT_LEN` system clocks is ignored and does not disturb a transfer.
- R11: The pull-down output changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Strapped low identity bits |
| sda_pd_o | output | 1 | Data line pull-down enable, active high |
| cfg_o | output | 40 | Register bank contents, register k at bits 8k+7..8k |
| commit_valid_o | output | 1 | One-cycle strobe when a write is applied |
| commit_addr_o | output | 3 | Register index of the applied write |
| commit_data_o | output | 8 | Data of the applied write |

## Verification
A stop condition and the completion of a write data byte can land in the same cycle window. The stop decides whether a pending byte is applied or discarded, and the data-byte path decides whether a byte becomes pending. The bench provokes this in two ways. It cuts a write off with a stop after half of the data bits. It also sends a write whose data byte is completed and acknowledged, then adds a second, refused byte before the stop. It judges both cases at the ports: by the register contents on `cfg_o` and by how many commit strobes were seen, with what address and data.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  localparam logic [3:0] ID_PREFIX = 4'b0101;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ID_RX,
    ST_ID_ACK,
    ST_ADDR_RX,
    ST_ADDR_ACK,
    ST_DATA_RX,
    ST_DATA_ACK,
    ST_RD_TX,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/cfg_i2c_line_filter.sv
module cfg_i2c_line_filter #(
  parameter int  FILT_LEN = 4,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(FILT_LEN - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {2{RST_VAL}};
      cnt_q  <= '0;
      out_q  <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == out_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_MAX) begin
        cnt_q <= '0;
        out_q <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = out_q;

  // filtered level only moves to a value the synchronised line already shows
  AST_FILT_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q != $past(out_q)) |-> (out_q == $past(sync_q[1]))); // R10
endmodule

// File: rtl/cfg_i2c_reg_bank.sv
module cfg_i2c_reg_bank #(
  parameter int NREG = 5,
  parameter int AW   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic [7:0]       rd_ptr_i,
  output logic [7:0]       rd_data_o,
  output logic [NREG*8-1:0] cfg_o
);
  localparam logic [7:0] NREG_B = 8'(NREG);

  logic [7:0] mem_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[i] <= '0;
      end else if (wr_en_i && (wr_addr_i == AW'(i))) begin
        mem_q[i] <= wr_data_i;
      end
    end
    assign cfg_o[i*8 +: 8] = mem_q[i];
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NREG; k++) begin
      if ((rd_ptr_i < NREG_B) && (rd_ptr_i[AW-1:0] == AW'(k))) rd_data_o = mem_q[k];
    end
  end

  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_o)); // R4
endmodule

// File: rtl/cfg_i2c_fsm.sv
module cfg_i2c_fsm
  import cfg_i2c_pkg::*;
#(
  parameter int NREG = 5,
  parameter int AW   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    strap_i,
  input  logic [7:0]    rd_data_i,
  output logic [7:0]    rd_ptr_o,
  output logic          sda_pd_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o
);
  localparam logic [7:0] NREG_B = 8'(NREG);

  tgt_state_e state_q;
  logic [2:0] cnt_q;
  logic       full_q;
  logic [7:0] rx_sh_q, tx_sh_q, ptr_q, wr_a_q, wr_d_q;
  logic       rd_mode_q, wr_pend_q, mack_q, pd_q;
  logic       scl_d_q, sda_d_q;
  logic       commit_q;
  logic [AW-1:0] commit_a_q;
  logic [7:0] commit_d_q;

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_i & ~scl_d_q;
  assign scl_fall = ~scl_i & scl_d_q;
  assign start_c  = scl_i & scl_d_q & sda_d_q & ~sda_i;
  assign stop_c   = scl_i & scl_d_q & ~sda_d_q & sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      full_q     <= 1'b0;
      rx_sh_q    <= '0;
      tx_sh_q    <= '0;
      ptr_q      <= '0;
      wr_a_q     <= '0;
      wr_d_q     <= '0;
      rd_mode_q  <= 1'b0;
      wr_pend_q  <= 1'b0;
      mack_q     <= 1'b0;
      pd_q       <= 1'b0;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
      commit_q   <= 1'b0;
      commit_a_q <= '0;
      commit_d_q <= '0;
    end else begin
      scl_d_q  <= scl_i;
      sda_d_q  <= sda_i;
      commit_q <= 1'b0;
      if (stop_c) begin
        state_q   <= ST_IDLE;
        pd_q      <= 1'b0;
        cnt_q     <= '0;
        full_q    <= 1'b0;
        wr_pend_q <= 1'b0;
        if (wr_pend_q && (wr_a_q < NREG_B)) begin
          commit_q   <= 1'b1;
          commit_a_q <= wr_a_q[AW-1:0];
          commit_d_q <= wr_d_q;
        end
      end else if (start_c) begin
        // a repeated start also drops any write not yet closed by a stop
        state_q   <= ST_ID_RX;
        pd_q      <= 1'b0;
        cnt_q     <= '0;
        full_q    <= 1'b0;
        wr_pend_q <= 1'b0;
      end else if (scl_rise) begin
        unique case (state_q)
          ST_ID_RX, ST_ADDR_RX, ST_DATA_RX: begin
            rx_sh_q <= {rx_sh_q[6:0], sda_i};
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == 3'd7) full_q <= 1'b1;
          end
          ST_RD_TX: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == 3'd7) full_q <= 1'b1;
          end
          ST_RD_ACK: mack_q <= ~sda_i;
          default: ;
        endcase
      end else if (scl_fall) begin
        unique case (state_q)
          ST_ID_RX: if (full_q) begin
            full_q <= 1'b0;
            if (rx_sh_q[7:1] == {ID_PREFIX, strap_i}) begin
              rd_mode_q <= rx_sh_q[0];
              pd_q      <= 1'b1;
              state_q   <= ST_ID_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_ADDR_RX: if (full_q) begin
            full_q  <= 1'b0;
            ptr_q   <= rx_sh_q;
            pd_q    <= 1'b1;
            state_q <= ST_ADDR_ACK;
          end
          ST_DATA_RX: if (full_q) begin
            full_q  <= 1'b0;
            wr_d_q  <= rx_sh_q;
            wr_a_q  <= ptr_q;
            pd_q    <= 1'b1;
            state_q <= ST_DATA_ACK;
          end
          ST_ID_ACK: begin
            if (rd_mode_q) begin
              tx_sh_q <= rd_data_i;
              pd_q    <= ~rd_data_i[7];
              state_q <= ST_RD_TX;
            end else begin
              pd_q    <= 1'b0;
              state_q <= ST_ADDR_RX;
            end
          end
          ST_ADDR_ACK: begin
            pd_q    <= 1'b0;
            state_q <= ST_DATA_RX;
          end
          ST_DATA_ACK: begin
            // byte and its acknowledge clock are complete: eligible for commit
            pd_q      <= 1'b0;
            wr_pend_q <= 1'b1;
            state_q   <= ST_IDLE;
          end
          ST_RD_TX: begin
            if (full_q) begin
              full_q  <= 1'b0;
              pd_q    <= 1'b0;
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_RD_ACK;
            end else begin
              tx_sh_q <= {tx_sh_q[6:0], 1'b0};
              pd_q    <= ~tx_sh_q[6];
            end
          end
          ST_RD_ACK: begin
            if (mack_q) begin
              tx_sh_q <= rd_data_i;
              pd_q    <= ~rd_data_i[7];
              state_q <= ST_RD_TX;
            end else begin
              pd_q    <= 1'b0;
              state_q <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_ptr_o  = ptr_q;
  assign sda_pd_o  = pd_q;
  assign wr_en_o   = commit_q;
  assign wr_addr_o = commit_a_q;
  assign wr_data_o = commit_d_q;

  AST_PD_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_q != $past(pd_q)) |-> !scl_i); // R11
  AST_COMMIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |=> !commit_q); // R3
  AST_COMMIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |-> ($past(wr_a_q) < NREG_B)); // R8
  AST_COMMIT_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(commit_q) |-> $past(stop_c)); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !pd_q); // R2
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
  parameter int NREG     = 5,
  parameter int FILT_LEN = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scl_i,
  input  logic                     sda_i,
  input  logic [2:0]               strap_i,
  output logic                     sda_pd_o,
  output logic [NREG*8-1:0]        cfg_o,
  output logic                     commit_valid_o,
  output logic [$clog2(NREG)-1:0]  commit_addr_o,
  output logic [7:0]               commit_data_o
);
  localparam int AW = $clog2(NREG);

  logic          scl_f, sda_f;
  logic [7:0]    rd_ptr, rd_data;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  cfg_i2c_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_scl_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(scl_i), .line_o(scl_f));

  cfg_i2c_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_sda_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(sda_i), .line_o(sda_f));

  cfg_i2c_fsm #(.NREG(NREG), .AW(AW)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_f), .sda_i(sda_f),
    .strap_i(strap_i), .rd_data_i(rd_data), .rd_ptr_o(rd_ptr),
    .sda_pd_o(sda_pd_o), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data));

  cfg_i2c_reg_bank #(.NREG(NREG), .AW(AW)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_ptr_i(rd_ptr), .rd_data_o(rd_data),
    .cfg_o(cfg_o));

  assign commit_valid_o = wr_en;
  assign commit_addr_o  = wr_addr;
  assign commit_data_o  = wr_data;
endmodule

// File: tb/cfg_i2c_target_tb.sv
module cfg_i2c_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 16;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] ID_W  = 8'h5A;
  localparam logic [7:0] ID_R  = 8'h5B;
  localparam logic [7:0] ID_BAD = 8'h58;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_bus;
  logic sda_pd;
  logic [39:0] cfg;
  logic commit_v;
  logic [2:0] commit_a;
  logic [7:0] commit_d;

  int checks = 0, failures = 0;
  int n_commit = 0;
  logic [2:0] c_addr;
  logic [7:0] c_data;
  int pd_bad = 0;
  logic pd_prev = 1'b0;
  logic [39:0] exp_cfg = '0;
  bit timeout = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_pd;

  cfg_i2c_target u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(STRAP), .sda_pd_o(sda_pd), .cfg_o(cfg),
    .commit_valid_o(commit_v), .commit_addr_o(commit_a), .commit_data_o(commit_d));

  always @(negedge clk) begin
    if (commit_v) begin
      n_commit = n_commit + 1;
      c_addr = commit_a;
      c_data = commit_d;
    end
    if (rst_n && (sda_pd != pd_prev) && scl_m) pd_bad = pd_bad + 1;
    pd_prev = sda_pd;
  end

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(QTR); scl_m = 1'b1; wq(QTR);
    sda_m = 1'b0; wq(QTR); scl_m = 1'b0; wq(QTR);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(QTR); scl_m = 1'b1; wq(QTR);
    sda_m = 1'b1; wq(4*QTR);
  endtask

  task automatic send_bit(input bit b, input bit glitch);
    sda_m = b;
    if (glitch) begin
      wq(QTR/2); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(QTR/2 - 2);
    end else wq(QTR);
    scl_m = 1'b1; wq(2*QTR); scl_m = 1'b0; wq(QTR);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i], glitch);
    sda_m = 1'b1; wq(QTR); scl_m = 1'b1; wq(QTR);
    ack = ~sda_bus;
    wq(QTR); scl_m = 1'b0; wq(QTR);
  endtask

  task automatic recv_byte(input bit ack_m, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(QTR); scl_m = 1'b1; wq(QTR);
      d[i] = sda_bus;
      wq(QTR); scl_m = 1'b0; wq(QTR);
    end
    sda_m = ~ack_m; wq(QTR); scl_m = 1'b1; wq(2*QTR); scl_m = 1'b0; wq(QTR);
    sda_m = 1'b1;
  endtask

  task automatic wr_txn(input logic [7:0] addr, input logic [7:0] data, input string req);
    bit a0, a1, a2;
    bus_start();
    send_byte(ID_W, 1'b0, a0);
    send_byte(addr, 1'b0, a1);
    send_byte(data, 1'b0, a2);
    bus_stop();
    chk(a0 && a1 && a2, req, {a0, a1, a2}, 3'b111);
  endtask

  task automatic t_reset();
    wq(4);
    chk(sda_pd == 1'b0, "R1 pd", sda_pd, 0);
    chk(cfg == '0, "R1 cfg", cfg, 0);
    chk(n_commit == 0, "R1 commit", n_commit, 0);
  endtask

  task automatic t_write();
    bit a0, a1, a2;
    int nc = n_commit;
    bus_start();
    send_byte(ID_W, 1'b0, a0);
    send_byte(8'h01, 1'b0, a1);
    send_byte(8'hA5, 1'b0, a2);
    chk(a0 && a1 && a2, "R2 R3 acks", {a0, a1, a2}, 3'b111);
    chk(cfg[15:8] == 8'h00, "R3 held until stop", cfg[15:8], 0);
    chk(n_commit == nc, "R3 no commit before stop", n_commit, nc);
    bus_stop();
    exp_cfg[15:8] = 8'hA5;
    chk(cfg == exp_cfg, "R3 cfg", cfg, exp_cfg);
    chk(n_commit == nc + 1, "R3 commit count", n_commit, nc + 1);
    chk({c_addr, c_data} == {3'd1, 8'hA5}, "R3 commit fields", {c_addr, c_data}, {3'd1, 8'hA5});
  endtask

  task automatic t_bad_id();
    bit a0, a1, a2;
    int nc = n_commit;
    bus_start();
    send_byte(ID_BAD, 1'b0, a0);
    send_byte(8'h02, 1'b0, a1);
    send_byte(8'hFF, 1'b0, a2);
    bus_stop();
    chk(!a0 && !a1 && !a2, "R2 mismatch nack", {a0, a1, a2}, 0);
    chk(cfg == exp_cfg, "R2 mismatch no change", cfg, exp_cfg);
    chk(n_commit == nc, "R2 mismatch no commit", n_commit, nc);
  endtask

  task automatic t_abort();
    bit a0, a1;
    int nc = n_commit;
    bus_start();
    send_byte(ID_W, 1'b0, a0);
    send_byte(8'h02, 1'b0, a1);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
    bus_stop();
    chk(cfg == exp_cfg, "R4 abort no change", cfg, exp_cfg);
    chk(n_commit == nc, "R4 abort no commit", n_commit, nc);
  endtask

  task automatic t_high_addr();
    int nc = n_commit;
    wr_txn(8'h07, 8'h3C, "R8 acked");
    chk(cfg == exp_cfg, "R8 discarded", cfg, exp_cfg);
    chk(n_commit == nc, "R8 no commit", n_commit, nc);
  endtask

  task automatic t_two_bytes();
    bit a0, a1, a2, a3;
    int nc = n_commit;
    bus_start();
    send_byte(ID_W, 1'b0, a0);
    send_byte(8'h03, 1'b0, a1);
    send_byte(8'h11, 1'b0, a2);
    send_byte(8'h22, 1'b0, a3);
    bus_stop();
    chk(a2 && !a3, "R9 second byte nack", {a2, a3}, 2'b10);
    exp_cfg[31:24] = 8'h11;
    chk(cfg == exp_cfg, "R9 first byte only", cfg, exp_cfg);
    chk(n_commit == nc + 1 && c_data == 8'h11, "R9 one commit", {n_commit[7:0], c_data}, {8'(nc + 1), 8'h11});
  endtask

  task automatic t_random_read();
    bit a0, a1, a2;
    logic [7:0] d0, d1, d2;
    wr_txn(8'h00, 8'h5A, "R3 setup0");
    wr_txn(8'h02, 8'hC3, "R3 setup2");
    wr_txn(8'h04, 8'h7E, "R3 setup4");
    exp_cfg[7:0] = 8'h5A; exp_cfg[23:16] = 8'hC3; exp_cfg[39:32] = 8'h7E;
    bus_start();
    send_byte(ID_W, 1'b0, a0);
    send_byte(8'h00, 1'b0, a1);
    bus_start();
    send_byte(ID_R, 1'b0, a2);
    chk(a0 && a1 && a2, "R6 acks", {a0, a1, a2}, 3'b111);
    recv_byte(1'b1, d0);
    recv_byte(1'b1, d1);
    recv_byte(1'b0, d2);
    wq(QTR);
    chk(sda_pd == 1'b0, "R7 released after nack", sda_pd, 0);
    bus_stop();
    chk(d0 == 8'h5A, "R6 first byte", d0, 8'h5A);
    chk({d1, d2} == {8'hA5, 8'hC3}, "R7 increment", {d1, d2}, {8'hA5, 8'hC3});
  endtask

  task automatic t_current_read();
    bit a0;
    logic [7:0] d0, d1;
    bus_start();
    send_byte(ID_R, 1'b0, a0);
    recv_byte(1'b1, d0);
    recv_byte(1'b0, d1);
    bus_stop();
    chk(a0 && d0 == 8'h11, "R5 current address", {a0, d0}, {1'b1, 8'h11});
    chk(d1 == 8'h7E, "R7 next byte", d1, 8'h7E);
    chk(sda_pd == 1'b0, "R7 idle released", sda_pd, 0);
  endtask

  task automatic t_glitch();
    bit a0, a1, a2;
    bus_start();
    send_byte(ID_W, 1'b1, a0);
    send_byte(8'h04, 1'b1, a1);
    send_byte(8'h81, 1'b1, a2);
    bus_stop();
    exp_cfg[39:32] = 8'h81;
    chk(a0 && a1 && a2, "R10 acks with glitches", {a0, a1, a2}, 3'b111);
    chk(cfg == exp_cfg, "R10 data with glitches", cfg, exp_cfg);
  endtask

  task automatic run_all();
    wq(5); rst_n = 1'b1;
    t_reset();
    t_write();
    t_bad_id();
    t_abort();
    t_high_addr();
    t_two_bytes();
    t_random_read();
    t_current_read();
    t_glitch();
    chk(pd_bad == 0, "R11 pd moves only with scl low", pd_bad, 0);
  endtask

  initial begin
    fork
      run_all();
      begin wq(150000); timeout = 1'b1; end
    join_any
    disable fork;
    if (timeout) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=expired expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule